// File: doc/BRIEF.md
# Timer Match and Edge-Count Unit

A pair of 16-bit down-counting timer channels, A and B, set up through a small word-addressed register port. Each channel has a reload value and a match value, and runs in one of four modes. In one-shot and periodic mode the match value is an interrupt compare point. In edge-count mode the counter decrements on chosen edges of an external input, and the match value sets where counting ends. In PWM mode the match value sets the point where the output falls within each reload period.

A concatenation bit joins the two halves into one 32-bit timer that runs on channel A. While it is set, the upper half of A's reload and match registers is channel B's own reload and match storage, and channel B is held idle. Every channel raises four sticky event flags. Software clears a flag by writing one to it. Each flag has a mask bit, and a channel's interrupt line is the OR of its unmasked flags.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset, the configuration word reads 0. Both channels' reload and match registers hold all ones: A's match register reads 0x0000FFFF while the halves are separate. Status reads 0, and both PWM outputs and both interrupt lines are low.
- R2: In one-shot mode (mode code 0) the counter loads the reload value one cycle after the enable is set and then decrements once per clock. The match flag sets one cycle after the counter equals the match value. On the cycle the counter is zero, the timeout flag sets on the next edge, the enable bit (configuration bit 4 for A) clears, and the counter stays at zero.
- R3: In periodic mode (code 1) the counter reloads on the clock after it reaches zero, so the timeout flag repeats every reload+1 cycles and the enable stays set.
- R4: In edge-count mode (code 2) each selected input edge decrements the counter. After exactly reload minus match edges, the done flag sets and the enable clears.
- R5: The two-bit edge-select field (bits 3:2 for A) counts rising edges for 0, falling edges for 1, and both edges for 2 or 3. Each input passes through two synchronizing flops.
- R6: Enabling edge-count mode with reload not greater than match sets the configuration-error flag and clears the enable on the next edge, leaving the counter unloaded.
- R7: In PWM mode (code 3) the output is high while the counter runs from the reload value down to the match value, and low for the rest of each reload+1-cycle period. The output is low whenever the channel is disabled.
- R8: With the concatenation bit (configuration bit 16) set, writing A's match or reload address stores the upper 16 bits into B's register. A reads back 32 bits and counts as one 32-bit timer.
- R9: With the halves separate, the upper 16 bits of A's match and reload reads are zero, and writes to them leave B's registers unchanged.
- R10: Status flags are sticky until a one is written to their bit at the status address. A set flag drives its channel's interrupt line only while its mask bit is set.
- R11: Each channel has a four-bit status nibble, A in bits 3:0 and B in bits 7:4, ordered timeout, match, done, configuration error. Mask bits use the same positions. irq_o[0] belongs to A and irq_o[1] to B.
- R12: Word addresses are: 0 configuration, 1 A reload, 2 A match, 3 B reload, 4 B match, 5 A counter, 6 B counter, 7 status, 8 mask. In the configuration word, channel A's fields start at bit 0 and channel B's at bit 8 (mode 1:0, edge select 3:2, enable 4), and bit 16 is the concatenation bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| edge_i | input | 2 | Asynchronous edge inputs, bit 0 for A, bit 1 for B |
| pwm_o | output | 2 | PWM outputs per channel |
| irq_o | output | 2 | Interrupt lines per channel |

## Verification
Every piece of channel state can be read back at the register port: the counter, the enable bit and the sticky flags. A wrong next-state choice therefore shows as a wrong counter value or a flag that sets one cycle late or early. The bench samples those cycles exactly. A wrong edge decode or synchronizer depth shows as a counter that moves on the wrong half of a pulse, within three cycles of the input change. A register-split fault appears on the first read of the other half after a write.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W     = 4;
  localparam int NCH        = 2;
  localparam int EV_W       = 4;
  localparam int EV_TIMEOUT = 0;
  localparam int EV_MATCH   = 1;
  localparam int EV_DONE    = 2;
  localparam int EV_CFGERR  = 3;

  localparam int CFG_STRIDE = 8;
  localparam int CFG_MODE   = 0;
  localparam int CFG_ESEL   = 2;
  localparam int CFG_EN     = 4;
  localparam int CFG_CAT    = 16;

  localparam logic [ADDR_W-1:0] A_CFG  = 4'h0;
  localparam logic [ADDR_W-1:0] A_RL_A = 4'h1;
  localparam logic [ADDR_W-1:0] A_MT_A = 4'h2;
  localparam logic [ADDR_W-1:0] A_RL_B = 4'h3;
  localparam logic [ADDR_W-1:0] A_MT_B = 4'h4;
  localparam logic [ADDR_W-1:0] A_CN_A = 4'h5;
  localparam logic [ADDR_W-1:0] A_CN_B = 4'h6;
  localparam logic [ADDR_W-1:0] A_STS  = 4'h7;
  localparam logic [ADDR_W-1:0] A_MSK  = 4'h8;

  typedef enum logic [1:0] {
    MD_ONESHOT  = 2'd0,
    MD_PERIODIC = 2'd1,
    MD_EDGE     = 2'd2,
    MD_PWM      = 2'd3
  } mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            cur;
  logic            prv;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din_i};
    cur  = sh_q[STAGES-1];
    prv  = sh_q[STAGES];
    case (sel_i)
      2'd0:    pulse_o = cur & ~prv;
      2'd1:    pulse_o = ~cur & prv;
      default: pulse_o = cur ^ prv;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  mode_e           mode_i,
  input  logic            edge_pulse_i,
  input  logic [CW-1:0]   rl_i,
  input  logic [CW-1:0]   mv_i,
  output logic [CW-1:0]   cnt_o,
  output logic            pwm_o,
  output logic [EV_W-1:0] ev_o,
  output logic            stop_o
);
  logic [CW-1:0] cnt_q, cnt_d, dec;
  logic          pwm_q, pwm_d;
  logic          run_q, run_d;
  logic          start;

  always_comb begin
    cnt_d  = cnt_q;
    pwm_d  = pwm_q;
    ev_o   = '0;
    stop_o = 1'b0;
    dec    = cnt_q - 1'b1;
    start  = en_i & ~run_q;
    if (!en_i) begin
      pwm_d = 1'b0;
    end else if (start) begin
      if (mode_i == MD_EDGE && rl_i <= mv_i) begin
        ev_o[EV_CFGERR] = 1'b1;
        stop_o          = 1'b1;
      end else begin
        cnt_d = rl_i;
        pwm_d = (mode_i == MD_PWM);
      end
    end else begin
      case (mode_i)
        MD_ONESHOT, MD_PERIODIC: begin
          if (cnt_q == mv_i) ev_o[EV_MATCH] = 1'b1;
          if (cnt_q == '0) begin
            ev_o[EV_TIMEOUT] = 1'b1;
            if (mode_i == MD_ONESHOT) stop_o = 1'b1;
            else                      cnt_d  = rl_i;
          end else begin
            cnt_d = dec;
          end
        end
        MD_EDGE: begin
          if (edge_pulse_i) begin
            cnt_d = dec;
            if (dec == mv_i) begin
              ev_o[EV_DONE] = 1'b1;
              stop_o        = 1'b1;
            end
          end
        end
        default: begin
          if (cnt_q == '0) begin
            cnt_d = rl_i;
            pwm_d = 1'b1;
          end else begin
            cnt_d = dec;
            if (cnt_q == mv_i) pwm_d = 1'b0;
          end
        end
      endcase
    end
    run_d = en_i & ~stop_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/tmr_irq_ctl.sv
`timescale 1ns/1ps
module tmr_irq_ctl #(
  parameter int NCH = 2,
  parameter int EVW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*EVW-1:0] ev_i,
  input  logic               clr_we_i,
  input  logic               msk_we_i,
  input  logic [NCH*EVW-1:0] wdat_i,
  output logic [NCH*EVW-1:0] sts_o,
  output logic [NCH*EVW-1:0] msk_o,
  output logic [NCH-1:0]     irq_o
);
  localparam int SW = NCH * EVW;
  logic [SW-1:0] sts_q, sts_d, msk_q, clr_m;
  logic          sts_le;

  always_comb begin
    clr_m  = clr_we_i ? wdat_i : '0;
    sts_d  = (sts_q & ~clr_m) | ev_i;
    sts_le = clr_we_i | (|ev_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_le) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msk_q <= '0;
    else if (msk_we_i) msk_q <= wdat_i;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    assign irq_o[i] = |(sts_q[i*EVW +: EVW] & msk_q[i*EVW +: EVW]);
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
endmodule

// File: rtl/tmr_match_unit.sv
`timescale 1ns/1ps
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*HW-1:0]   wdata_i,
  output logic [2*HW-1:0]   rdata_o,
  input  logic [NCH-1:0]    edge_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int CW = 2 * HW;
  localparam int SW = NCH * EV_W;

  logic [1:0]    mode_v [NCH];
  logic [1:0]    esel_v [NCH];
  logic [NCH-1:0] en_v;
  logic [HW-1:0] rl_v   [NCH];
  logic [HW-1:0] mt_v   [NCH];
  logic [CW-1:0] rl_eff [NCH];
  logic [CW-1:0] mv_eff [NCH];
  logic [CW-1:0] cnt_v  [NCH];
  logic [SW-1:0] ev_all, sts_v, msk_v;
  logic          cat_q;
  logic          cfg_we;
  logic [CW-1:0] cfg_rd;

  assign cfg_we = wr_i && (addr_i == A_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cat_q <= 1'b0;
    else if (cfg_we) cat_q <= wdata_i[CFG_CAT];
  end

  // Channel A sees a 32-bit value when the halves are joined.
  assign rl_eff[0] = cat_q ? {rl_v[1], rl_v[0]} : {{HW{1'b0}}, rl_v[0]};
  assign mv_eff[0] = cat_q ? {mt_v[1], mt_v[0]} : {{HW{1'b0}}, mt_v[0]};
  assign rl_eff[1] = {{HW{1'b0}}, rl_v[1]};
  assign mv_eff[1] = {{HW{1'b0}}, mt_v[1]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int OFS = i * CFG_STRIDE;
    localparam logic [ADDR_W-1:0] RL_ADDR = (i == 0) ? A_RL_A : A_RL_B;
    localparam logic [ADDR_W-1:0] MT_ADDR = (i == 0) ? A_MT_A : A_MT_B;

    logic [1:0]    mode_q, esel_q;
    logic          en_q, en_d, en_le, run_en;
    logic [HW-1:0] rl_q, rl_d, mt_q, mt_d;
    logic          rl_le, mt_le;
    logic          stop_w, pulse_w;
    logic [EV_W-1:0] ev_w;

    if (i == 0) begin : g_lo
      always_comb begin
        rl_le = wr_i && addr_i == RL_ADDR;
        mt_le = wr_i && addr_i == MT_ADDR;
        rl_d  = wdata_i[HW-1:0];
        mt_d  = wdata_i[HW-1:0];
      end
      assign run_en = en_q;
    end else begin : g_hi
      logic up_rl, up_mt;
      always_comb begin
        up_rl = cat_q && wr_i && addr_i == A_RL_A;
        up_mt = cat_q && wr_i && addr_i == A_MT_A;
        rl_le = up_rl || (wr_i && addr_i == RL_ADDR);
        mt_le = up_mt || (wr_i && addr_i == MT_ADDR);
        rl_d  = up_rl ? wdata_i[CW-1:HW] : wdata_i[HW-1:0];
        mt_d  = up_mt ? wdata_i[CW-1:HW] : wdata_i[HW-1:0];
      end
      assign run_en = en_q & ~cat_q;
    end

    always_comb begin
      en_le = cfg_we | stop_w;
      en_d  = stop_w ? 1'b0 : wdata_i[OFS+CFG_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= 2'd0;
        esel_q <= 2'd0;
      end else if (cfg_we) begin
        mode_q <= wdata_i[OFS+CFG_MODE +: 2];
        esel_q <= wdata_i[OFS+CFG_ESEL +: 2];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_le) en_q <= en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rl_q <= '1;
      else if (rl_le) rl_q <= rl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mt_q <= '1;
      else if (mt_le) mt_q <= mt_d;
    end

    tmr_edge_sync #(.STAGES(2)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din_i   (edge_i[i]),
      .sel_i   (esel_q),
      .pulse_o (pulse_w)
    );

    tmr_channel #(.CW(CW)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (run_en),
      .mode_i       (mode_e'(mode_q)),
      .edge_pulse_i (pulse_w),
      .rl_i         (rl_eff[i]),
      .mv_i         (mv_eff[i]),
      .cnt_o        (cnt_v[i]),
      .pwm_o        (pwm_o[i]),
      .ev_o         (ev_w),
      .stop_o       (stop_w)
    );

    assign mode_v[i] = mode_q;
    assign esel_v[i] = esel_q;
    assign en_v[i]   = en_q;
    assign rl_v[i]   = rl_q;
    assign mt_v[i]   = mt_q;
    assign ev_all[i*EV_W +: EV_W] = ev_w;
  end

  tmr_irq_ctl #(.NCH(NCH), .EVW(EV_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_all),
    .clr_we_i (wr_i && addr_i == A_STS),
    .msk_we_i (wr_i && addr_i == A_MSK),
    .wdat_i   (wdata_i[SW-1:0]),
    .sts_o    (sts_v),
    .msk_o    (msk_v),
    .irq_o    (irq_o)
  );

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NCH; i++) begin
      cfg_rd[i*CFG_STRIDE+CFG_MODE +: 2] = mode_v[i];
      cfg_rd[i*CFG_STRIDE+CFG_ESEL +: 2] = esel_v[i];
      cfg_rd[i*CFG_STRIDE+CFG_EN]        = en_v[i];
    end
    cfg_rd[CFG_CAT] = cat_q;
  end

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = cfg_rd;
      A_RL_A:  rdata_o = rl_eff[0];
      A_MT_A:  rdata_o = mv_eff[0];
      A_RL_B:  rdata_o = rl_eff[1];
      A_MT_B:  rdata_o = mv_eff[1];
      A_CN_A:  rdata_o = cnt_v[0];
      A_CN_B:  rdata_o = cnt_v[1];
      A_STS:   rdata_o = {{(CW-SW){1'b0}}, sts_v};
      A_MSK:   rdata_o = {{(CW-SW){1'b0}}, msk_v};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_match_unit_chk.sv
`timescale 1ns/1ps
module tmr_match_unit_chk
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CW-1:0]     rdata_o,
  input logic              cat,
  input logic              en_a,
  input logic [1:0]        mode_a,
  input logic [CW-1:0]     cnt_a,
  input logic [CW-1:0]     rl_a,
  input logic [CW-1:0]     mv_a,
  input logic              pwm_a,
  input logic              irq_a,
  input logic [EV_W-1:0]   sts_a,
  input logic [EV_W-1:0]   msk_a
);
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && $past(en_a) && mode_a == 2'd0 && cnt_a == '0) |=> !en_a); // R2
  AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && $past(en_a) && mode_a == 2'd1 && cnt_a == '0 && !wr_i) |=> (cnt_a == $past(rl_a))); // R3
  AST_BAD_EDGE_CFG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && !$past(en_a) && mode_a == 2'd2 && rl_a <= mv_a) |=> !en_a); // R6
  AST_PWM_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |=> !pwm_a); // R7
  AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cat && addr_i == A_MT_A) |-> (rdata_o[CW-1:CW/2] == '0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_a[0] && !wr_i) |=> sts_a[0]); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (msk_a != '0)); // R10
endmodule

bind tmr_match_unit tmr_match_unit_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .cat     (cat_q),
  .en_a    (en_v[0]),
  .mode_a  (mode_v[0]),
  .cnt_a   (cnt_v[0]),
  .rl_a    (rl_eff[0]),
  .mv_a    (mv_eff[0]),
  .pwm_a   (pwm_o[0]),
  .irq_a   (irq_o[0]),
  .sts_a   (sts_v[3:0]),
  .msk_a   (msk_v[3:0])
);

// File: tb/tmr_match_unit_tb.sv
`timescale 1ns/1ps
module tmr_match_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  edge_in;
  logic [1:0]  pwm;
  logic [1:0]  irq;
  int          nchk = 0;
  int          nbad = 0;
  bit          fin = 1'b0;

  always #2.5 clk = ~clk;

  tmr_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .edge_i(edge_in), .pwm_o(pwm), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{1'b0, 4'h0, 32'h0,         32'h0},
    '{1'b0, 4'h1, 32'h0,         32'h0000FFFF},
    '{1'b0, 4'h2, 32'h0,         32'h0000FFFF},
    '{1'b0, 4'h4, 32'h0,         32'h0000FFFF},
    '{1'b0, 4'h7, 32'h0,         32'h0},
    '{1'b1, 4'h4, 32'h000000AB,  32'h0},
    '{1'b1, 4'h2, 32'h55550011,  32'h0},
    '{1'b0, 4'h2, 32'h0,         32'h00000011},
    '{1'b0, 4'h4, 32'h0,         32'h000000AB}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse0();
    edge_in[0] = 1'b1; waitc(4);
    edge_in[0] = 1'b0; waitc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int hi;
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; edge_in = '0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    chk("R1 pwm after reset", {30'd0, pwm}, 32'd0);
    chk("R1 irq after reset", {30'd0, irq}, 32'd0);

    // R12 R1 R9: table walk over reset values and split-half writes
    for (int k = 0; k < 9; k++) begin
      if (VT[k].wr) wr_reg(VT[k].a, VT[k].d);
      else rd_chk(VT[k].a, VT[k].e, $sformatf("R12 R1 R9 vector %0d", k));
    end

    // R2 one-shot
    wr_reg(4'h7, 32'hFF);
    wr_reg(4'h1, 32'd5);
    wr_reg(4'h2, 32'd3);
    wr_reg(4'h0, 32'h10);
    waitc(3);
    rd_chk(4'h5, 32'd3, "R2 counter at match");
    rd_chk(4'h7, 32'h0, "R2 match flag not yet");
    waitc(1);
    rd_chk(4'h7, 32'h2, "R2 match flag set");
    waitc(2);
    rd_chk(4'h5, 32'd0, "R2 counter zero");
    rd_chk(4'h7, 32'h2, "R2 timeout not yet");
    waitc(1);
    rd_chk(4'h7, 32'h3, "R2 timeout flag");
    rd_chk(4'h0, 32'h0, "R2 enable cleared");
    waitc(2);
    rd_chk(4'h5, 32'd0, "R2 counter held");

    // R3 periodic
    wr_reg(4'h7, 32'hFF);
    wr_reg(4'h1, 32'd4);
    wr_reg(4'h2, 32'd100);
    wr_reg(4'h0, 32'h11);
    waitc(5);
    rd_chk(4'h5, 32'd0, "R3 counter zero");
    rd_chk(4'h7, 32'h0, "R3 no timeout yet");
    waitc(1);
    rd_chk(4'h5, 32'd4, "R3 reloaded");
    rd_chk(4'h7, 32'h1, "R3 timeout without match");
    rd_chk(4'h0, 32'h11, "R3 enable kept");
    wr_reg(4'h0, 32'h0);

    // R4 edge count, rising
    wr_reg(4'h7, 32'hFF);
    wr_reg(4'h1, 32'd10);
    wr_reg(4'h2, 32'd7);
    wr_reg(4'h0, 32'h12);
    pulse0(); pulse0();
    rd_chk(4'h5, 32'd8, "R4 two edges counted");
    rd_chk(4'h7, 32'h0, "R4 not done early");
    pulse0();
    rd_chk(4'h7, 32'h4, "R4 done after reload-match edges");
    rd_chk(4'h0, 32'h02, "R4 enable cleared");

    // R5 falling edge select
    wr_reg(4'h1, 32'd10);
    wr_reg(4'h2, 32'd0);
    wr_reg(4'h0, 32'h16);
    edge_in[0] = 1'b1; waitc(4);
    rd_chk(4'h5, 32'd10, "R5 rising ignored in falling mode");
    edge_in[0] = 1'b0; waitc(4);
    rd_chk(4'h5, 32'd9, "R5 falling counted");
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h0, 32'h1A);
    pulse0();
    rd_chk(4'h5, 32'd8, "R5 both edges counted");
    wr_reg(4'h0, 32'h0);

    // R6 configuration error
    wr_reg(4'h7, 32'hFF);
    wr_reg(4'h1, 32'd5);
    wr_reg(4'h2, 32'd5);
    wr_reg(4'h0, 32'h12);
    waitc(1);
    rd_chk(4'h7, 32'h8, "R6 error flag");
    rd_chk(4'h0, 32'h02, "R6 enable cleared");
    rd_chk(4'h5, 32'd8, "R6 counter not loaded");

    // R7 PWM
    wr_reg(4'h1, 32'd9);
    wr_reg(4'h2, 32'd3);
    wr_reg(4'h0, 32'h13);
    waitc(3);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      if (pwm[0]) hi++;
      waitc(1);
    end
    chk("R7 high cycles in two periods", hi, 32'd14);
    wr_reg(4'h0, 32'h0);
    waitc(1);
    chk("R7 low when disabled", {31'd0, pwm[0]}, 32'd0);

    // R8 joined halves
    wr_reg(4'h0, 32'h10000);
    wr_reg(4'h2, 32'h00020005);
    rd_chk(4'h4, 32'h2, "R8 upper match in B");
    rd_chk(4'h2, 32'h00020005, "R8 32-bit match read");
    wr_reg(4'h1, 32'h00010000);
    rd_chk(4'h3, 32'h1, "R8 upper reload in B");
    wr_reg(4'h0, 32'h10011);
    waitc(1);
    rd_chk(4'h5, 32'h00010000, "R8 32-bit load");
    waitc(1);
    rd_chk(4'h5, 32'h0000FFFF, "R8 borrow across halves");
    wr_reg(4'h0, 32'h0);

    // R9 split halves
    wr_reg(4'h2, 32'hABCD1234);
    rd_chk(4'h2, 32'h00001234, "R9 upper reads zero");
    rd_chk(4'h4, 32'h2, "R9 B match untouched");

    // R10 R11 status and mask
    wr_reg(4'h7, 32'hFF);
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h1, 32'd2);
    wr_reg(4'h2, 32'd1);
    wr_reg(4'h0, 32'h10);
    waitc(6);
    rd_chk(4'h7, 32'h03, "R11 A timeout and match bits");
    chk("R10 masked flag silent", {30'd0, irq}, 32'd0);
    wr_reg(4'h8, 32'h01);
    chk("R10 unmasked flag drives irq", {30'd0, irq}, 32'd1);
    wr_reg(4'h7, 32'h02);
    rd_chk(4'h7, 32'h01, "R10 write-one clears only its bit");
    chk("R10 irq stays", {30'd0, irq}, 32'd1);
    wr_reg(4'h7, 32'h01);
    chk("R10 irq drops after clear", {30'd0, irq}, 32'd0);
    wr_reg(4'h8, 32'h10);
    wr_reg(4'h3, 32'd3);
    wr_reg(4'h4, 32'd1);
    wr_reg(4'h0, 32'h1000);
    waitc(8);
    rd_chk(4'h7, 32'h30, "R11 B nibble");
    chk("R11 B irq line", {30'd0, irq}, 32'd2);
    rd_chk(4'h6, 32'd0, "R11 B counter stopped");

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule